// File: doc/BRIEF.md
# IEEE Double Operand Input Screener

This block sits in front of a double-precision floating-point datapath and inspects each incoming 64-bit operand. It splits the operand into its sign, 11-bit biased exponent and 52-bit fraction, and sorts it into one of five classes: true zero, subnormal, normal, infinity or NaN. From that class, a flush-subnormals control bit and a two-bit screening mode, it decides whether to pass the operand on unchanged, replace it with a zero that keeps the sign, or flag an arithmetic trap with a cause code.

Three screening policies exist. Arithmetic screening traps on every non-finite input. Compare screening lets infinities through and traps only on NaNs. Completion screening leaves exception handling to the operation that follows. It only flushes subnormals and never traps. The block is one registered stage. The operand is still presented on a trap cycle, so whatever receives the trap also sees the value that caused it.

Top module: `fp_operand_screen`

## Requirements
- R1: The sign is bit 63, the biased exponent is bits 62:52 and the fraction is bits 51:0. Normal numbers and zeros of either sign leave the block unchanged and without a trap, in every mode.
- R2: A subnormal operand (exponent zero, fraction nonzero) with the flush control set comes out as its sign bit followed by 63 zero bits, without a trap, in every mode.
- R3: In arithmetic and compare modes, a subnormal operand with the flush control clear raises a trap with cause 3'b100 (underflow). The operand comes out unchanged.
- R4: In arithmetic mode, an all-ones exponent raises a trap. The cause is 3'b001 (invalid) for a nonzero fraction and 3'b010 (overflow) for a zero fraction. The operand comes out unchanged.
- R5: In compare mode, infinities of either sign pass unchanged without a trap. NaNs trap with cause 3'b001.
- R6: In completion mode, nothing ever traps. With the flush control set, every operand whose exponent is zero is reduced to its sign bit. Every other operand passes unchanged.
- R7: The mode encoding is 2'd0 arithmetic, 2'd1 compare and 2'd2 completion. Code 2'd3 behaves exactly like arithmetic.
- R8: All outputs are registered with one cycle of latency: out_valid repeats in_valid one clock later. out_trap is asserted only together with out_valid. out_cause is 3'b000 whenever out_trap is low.
- R9: While reset is high at a clock edge, out_valid, out_trap, out_cause and out_opnd all become zero.
- R10: A cycle with in_valid low raises neither out_valid nor out_trap and leaves out_opnd holding its previous value, whatever operand, mode or flush value is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_opnd | input | 64 | Operand to screen |
| in_mode | input | 2 | Screening policy (0 arith, 1 compare, 2 completion, 3 as arith) |
| in_flush | input | 1 | Flush subnormals to signed zero |
| out_valid | output | 1 | Screened operand present |
| out_opnd | output | 64 | Screened operand |
| out_trap | output | 1 | Arithmetic trap requested for this operand |
| out_cause | output | 3 | One-hot cause: bit0 invalid, bit1 overflow, bit2 underflow |

## Verification
The assertions assume that mode, flush control and operand are stable across each sampling edge, and that each input cycle stands on its own: no state carries from one operand to the next except the held output operand. The bench changes every input only on the falling clock edge and holds it until the next falling edge. Each vector therefore enters exactly one rising edge with well-defined values, including idle cycles that carry hostile operands such as NaNs.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;

  typedef enum logic [1:0] {
    MODE_ARITH = 2'd0,
    MODE_CMP   = 2'd1,
    MODE_SWC   = 2'd2,
    MODE_RSVD  = 2'd3
  } scr_mode_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } scr_class_e;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_INV = 0;
  localparam int CAUSE_OVF = 1;
  localparam int CAUSE_UNF = 2;

endpackage

// File: rtl/fpscr_classify.sv
module fpscr_classify
  import fpscr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output scr_class_e        cls_o
);

  logic exp_zero;
  logic exp_ones;
  logic frac_nz;

  assign exp_zero = (exp_i == '0);
  assign exp_ones = (exp_i == '1);
  assign frac_nz  = (frac_i != '0);

  always_comb begin
    if (exp_zero)      cls_o = frac_nz ? CLS_SUB : CLS_ZERO;
    else if (exp_ones) cls_o = frac_nz ? CLS_NAN : CLS_INF;
    else               cls_o = CLS_NORM;
  end

endmodule

// File: rtl/fpscr_policy.sv
module fpscr_policy
  import fpscr_pkg::*;
#(
  parameter int W = 64
) (
  input  scr_class_e         cls_i,
  input  scr_mode_e          mode_i,
  input  logic               flush_i,
  input  logic [W-1:0]       opnd_i,
  output logic [W-1:0]       opnd_o,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [W-1:0] signed_zero;
  logic         swc;
  logic         arith_like;

  assign signed_zero = {opnd_i[W-1], {(W-1){1'b0}}};
  assign swc         = (mode_i == MODE_SWC);
  assign arith_like  = (mode_i == MODE_ARITH) || (mode_i == MODE_RSVD);

  always_comb begin
    opnd_o  = opnd_i;
    trap_o  = 1'b0;
    cause_o = '0;
    unique case (cls_i)
      CLS_ZERO: begin
        if (swc && flush_i) opnd_o = signed_zero;
      end
      CLS_SUB: begin
        if (flush_i) begin
          opnd_o = signed_zero;
        end else if (!swc) begin
          trap_o             = 1'b1;
          cause_o[CAUSE_UNF] = 1'b1;
        end
      end
      CLS_INF: begin
        if (arith_like) begin
          trap_o             = 1'b1;
          cause_o[CAUSE_OVF] = 1'b1;
        end
      end
      CLS_NAN: begin
        if (!swc) begin
          trap_o             = 1'b1;
          cause_o[CAUSE_INV] = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
  import fpscr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [EXP_W+FRAC_W:0]         in_opnd,
  input  logic [1:0]                    in_mode,
  input  logic                          in_flush,
  output logic                          out_valid,
  output logic [EXP_W+FRAC_W:0]         out_opnd,
  output logic                          out_trap,
  output logic [fpscr_pkg::CAUSE_W-1:0] out_cause
);

  localparam int W = EXP_W + FRAC_W + 1;

  scr_class_e         cls;
  logic [W-1:0]       nxt_opnd;
  logic               nxt_trap;
  logic [CAUSE_W-1:0] nxt_cause;

  fpscr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_i  (in_opnd[W-2 -: EXP_W]),
    .frac_i (in_opnd[FRAC_W-1:0]),
    .cls_o  (cls)
  );

  fpscr_policy #(.W(W)) u_pol (
    .cls_i   (cls),
    .mode_i  (scr_mode_e'(in_mode)),
    .flush_i (in_flush),
    .opnd_i  (in_opnd),
    .opnd_o  (nxt_opnd),
    .trap_o  (nxt_trap),
    .cause_o (nxt_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_opnd  <= '0;
      out_trap  <= 1'b0;
      out_cause <= '0;
    end else begin
      out_valid <= in_valid;
      out_trap  <= in_valid & nxt_trap;
      out_cause <= in_valid ? nxt_cause : '0;
      if (in_valid) out_opnd <= nxt_opnd;
    end
  end

  // R8
  trap_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> out_valid);

  // R8
  cause_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_trap ? ($countones(out_cause) == 1) : (out_cause == '0));

  // R6
  swc_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd2) |=> !out_trap);

  // R1
  normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opnd[W-2 -: EXP_W] != '0 && in_opnd[W-2 -: EXP_W] != '1)
      |=> (!out_trap && out_opnd == $past(in_opnd)));

  // R2
  flush_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_flush && in_opnd[W-2 -: EXP_W] == '0 && in_opnd[FRAC_W-1:0] != '0)
      |=> (!out_trap && out_opnd == {$past(in_opnd[W-1]), {(W-1){1'b0}}}));

  // R5
  cmp_inf_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd1 && in_opnd[W-2 -: EXP_W] == '1 && in_opnd[FRAC_W-1:0] == '0)
      |=> (!out_trap && out_opnd == $past(in_opnd)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_trap && $stable(out_opnd)));

endmodule

// File: tb/fp_operand_screen_bench.sv
module fp_operand_screen_bench;

  localparam int CLK_P = 10;
  localparam int NV    = 17;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_opnd;
  logic [1:0]  in_mode;
  logic        in_flush;
  logic        out_valid;
  logic [63:0] out_opnd;
  logic        out_trap;
  logic [2:0]  out_cause;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fp_operand_screen u_fp_operand_screen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_mode(in_mode), .in_flush(in_flush), .out_valid(out_valid),
    .out_opnd(out_opnd), .out_trap(out_trap), .out_cause(out_cause)
  );

  // {mode, flush, operand, exp_trap, exp_cause, exp_out}
  localparam logic [134:0] VECS [NV] = '{
    {2'd0, 1'b0, 64'h3FF0000000000000, 1'b0, 3'b000, 64'h3FF0000000000000}, // R1
    {2'd0, 1'b0, 64'h0000000000000001, 1'b1, 3'b100, 64'h0000000000000001}, // R3
    {2'd0, 1'b1, 64'h800000000000ABCD, 1'b0, 3'b000, 64'h8000000000000000}, // R2
    {2'd0, 1'b0, 64'h7FF0000000000000, 1'b1, 3'b010, 64'h7FF0000000000000}, // R4
    {2'd0, 1'b1, 64'h7FF8000000000000, 1'b1, 3'b001, 64'h7FF8000000000000}, // R4
    {2'd1, 1'b0, 64'hFFF0000000000000, 1'b0, 3'b000, 64'hFFF0000000000000}, // R5
    {2'd1, 1'b0, 64'h7FF0000000000001, 1'b1, 3'b001, 64'h7FF0000000000001}, // R5
    {2'd1, 1'b0, 64'h0000000000000001, 1'b1, 3'b100, 64'h0000000000000001}, // R3
    {2'd1, 1'b1, 64'h8000000000000001, 1'b0, 3'b000, 64'h8000000000000000}, // R2
    {2'd2, 1'b0, 64'h0000000000000001, 1'b0, 3'b000, 64'h0000000000000001}, // R6
    {2'd2, 1'b1, 64'h800000000000ABCD, 1'b0, 3'b000, 64'h8000000000000000}, // R6
    {2'd2, 1'b0, 64'h7FF8000000000000, 1'b0, 3'b000, 64'h7FF8000000000000}, // R6
    {2'd2, 1'b1, 64'h0000000000000000, 1'b0, 3'b000, 64'h0000000000000000}, // R6
    {2'd0, 1'b0, 64'h8000000000000000, 1'b0, 3'b000, 64'h8000000000000000}, // R1
    {2'd3, 1'b0, 64'h7FF0000000000000, 1'b1, 3'b010, 64'h7FF0000000000000}, // R7
    {2'd2, 1'b1, 64'hC000000000000000, 1'b0, 3'b000, 64'hC000000000000000}, // R6
    {2'd0, 1'b1, 64'hFFEFFFFFFFFFFFFF, 1'b0, 3'b000, 64'hFFEFFFFFFFFFFFFF}  // R1
  };

  function automatic string row_req(int i);
    case (i)
      0, 13, 16:         return "R1";
      2, 8:              return "R2";
      1, 7:              return "R3";
      3, 4:              return "R4";
      5, 6:              return "R5";
      14:                return "R7";
      default:           return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic f,
                       input logic [63:0] op);
    @(negedge clk);
    in_valid = v; in_mode = m; in_flush = f; in_opnd = op;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_opnd = '0; in_mode = '0; in_flush = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid", 64'(out_valid), 64'd0);
    chk(out_trap == 1'b0, "R9", "out_trap", 64'(out_trap), 64'd0);
    chk(out_cause == 3'b000, "R9", "out_cause", 64'(out_cause), 64'd0);
    chk(out_opnd == 64'd0, "R9", "out_opnd", out_opnd, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [134:0] v;
      v = VECS[i];
      drive(1'b1, v[134:133], v[132], v[131:68]);
      chk(out_valid == 1'b1, row_req(i), "out_valid", 64'(out_valid), 64'd1);
      chk(out_trap == v[67], row_req(i), "out_trap", 64'(out_trap), 64'(v[67]));
      chk(out_cause == v[66:64], row_req(i), "out_cause", 64'(out_cause), 64'(v[66:64]));
      chk(out_opnd == v[63:0], row_req(i), "out_opnd", out_opnd, v[63:0]);
    end

    // R10 idle cycle with a hostile operand leaves output held
    drive(1'b1, 2'd0, 1'b0, 64'h4008000000000000);
    drive(1'b0, 2'd0, 1'b0, 64'h7FF8000000000000);
    chk(out_valid == 1'b0, "R10", "out_valid idle", 64'(out_valid), 64'd0);
    chk(out_trap == 1'b0, "R10", "out_trap idle", 64'(out_trap), 64'd0);
    chk(out_cause == 3'b000, "R10", "out_cause idle", 64'(out_cause), 64'd0);
    chk(out_opnd == 64'h4008000000000000, "R10", "out_opnd idle", out_opnd, 64'h4008000000000000);

    // R8 one cycle latency: a new trapping input is not visible before the edge
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'd0; in_flush = 1'b0; in_opnd = 64'hFFF0000000000000;
    #1;
    chk(out_trap == 1'b0, "R8", "trap before edge", 64'(out_trap), 64'd0);
    chk(out_opnd == 64'h4008000000000000, "R8", "opnd before edge", out_opnd, 64'h4008000000000000);
    @(posedge clk);
    #(CLK_P/4);
    chk(out_trap == 1'b1 && out_valid == 1'b1, "R8", "trap after edge", 64'(out_trap), 64'd1);
    chk(out_cause == 3'b010, "R4", "neg infinity cause", 64'(out_cause), 64'd2);

    // R9 reset while valid input is present
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    chk(out_valid == 1'b0 && out_trap == 1'b0, "R9", "mid-run reset flags",
        64'({out_valid, out_trap}), 64'd0);
    chk(out_opnd == 64'd0 && out_cause == 3'b000, "R9", "mid-run reset data", out_opnd, 64'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    finish_run();
  end

endmodule